// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces one pulse-width-modulated output for driving a display backlight. Software programs it over a plain register port with an address, a write strobe, write data and combinational read data. It writes a clock prescaler, a period and a high width into shadow registers. Those values reach the active timing registers only after a commit strobe. In bypass mode they reach them without one. In either case new values are taken only at the start of a PWM cycle, so a running pulse is never cut short.

Each cycle starts with the output high. The output stays high for a programmed number of prescaled ticks and is low for the rest of the cycle. The period field holds the cycle length in ticks minus one. The high-width field holds the raw tick count. A tick lasts the prescaler value plus one clocks.

A small state machine drives the output. Its states are `ST_OFF` (disabled, counters cleared), `ST_HIGH` (the output is high) and `ST_LOW` (the output is low for the rest of the cycle). It has five transitions:
- `start`: from `ST_OFF` when the enable bit is set, into `ST_HIGH`, or into `ST_LOW` if the high width is zero.
- `drop`: from `ST_HIGH` to `ST_LOW` on the tick where the tick count reaches the high width.
- `wrap`: from `ST_HIGH` or `ST_LOW` at the end of the period, into `ST_HIGH`, or into `ST_LOW` for a zero width, loading any pending values.
- `hold`: stay in the current state between ticks.
- `stop`: from either running state to `ST_OFF` when the enable bit is cleared.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the output is low and every register reads 0.
- R2: Reads return the shadow contents. The enable bit is bit 0 at 0x00. The commit bit is bit 0 at 0x08. At 0x10, bit 0 is bypass and bits [25:16] are the prescaler. At 0x14, bits [11:0] are the period and bits [28:16] are the high width. Other bits and addresses read 0.
- R3: With prescaler D, period P and high width H, where 0 < H <= P, the output repeats every (D+1)*(P+1) clocks and is high for the first H*(D+1) clocks of each cycle.
- R4: With bypass off, writing the shadow registers changes nothing until bit 0 at 0x08 goes from 0 to 1.
- R5: A commit made during a cycle leaves that cycle unchanged. The new values apply from the next cycle boundary.
- R6: With bypass on, shadow values apply at the next cycle boundary without a commit.
- R7: If H >= P+1, the output is high on every clock while enabled. If H = 0, the output stays low.
- R8: Clearing the enable bit drives the output low by the second clock edge and keeps it low. Register contents are kept. Setting the bit again starts a new cycle high.
- R9: The output is low whenever the enable bit is 0. Until the first commit or bypass load, the active values are zero, so the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The assertions check on every clock the rules that hold at all times:
- the prescale and period counters never pass their active limits;
- the active timing is stable except at a cycle boundary;
- each rising edge of the output coincides with a cycle start;
- the output goes low after the enable bit drops;
- a full-width setting holds the output high;
- the commit pulse lasts one cycle.

Only the bench scenarios can show the exact high and period lengths in clocks. They also show that uncommitted writes have no effect, that a commit made mid-cycle leaves the current pulse whole, that bypass applies values without a commit, and that the registers keep their contents across a disable.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int DIV_W  = 10;
    localparam int PER_W  = 12;
    localparam int HI_W   = 13;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_COMMIT = 8'h08;
    localparam logic [7:0] OFS_CTRL0  = 8'h10;
    localparam logic [7:0] OFS_CTRL1  = 8'h14;

    localparam int DIV_LSB = 16;
    localparam int HI_LSB  = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  hi;
    } timing_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic              bypass,
    output logic              load_req,
    output timing_t           shadow
);
    logic commit_bit;
    logic sel_en, sel_commit, sel_c0, sel_c1;

    always_comb begin
        sel_en     = (bus_addr == ADDR_W'(OFS_ENABLE));
        sel_commit = (bus_addr == ADDR_W'(OFS_COMMIT));
        sel_c0     = (bus_addr == ADDR_W'(OFS_CTRL0));
        sel_c1     = (bus_addr == ADDR_W'(OFS_CTRL1));
    end

    // Commit fires only on a 0-to-1 change of the stored strobe bit
    assign load_req = bus_wr && sel_commit && bus_wdata[0] && !commit_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en         <= 1'b0;
            bypass     <= 1'b0;
            commit_bit <= 1'b0;
            shadow     <= '0;
        end else if (bus_wr) begin
            if (sel_en)     en         <= bus_wdata[0];
            if (sel_commit) commit_bit <= bus_wdata[0];
            if (sel_c0) begin
                bypass     <= bus_wdata[0];
                shadow.div <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (sel_c1) begin
                shadow.per <= bus_wdata[PER_W-1:0];
                shadow.hi  <= bus_wdata[HI_LSB +: HI_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_en) begin
            bus_rdata[0] = en;
        end else if (sel_commit) begin
            bus_rdata[0] = commit_bit;
        end else if (sel_c0) begin
            bus_rdata[0]                  = bypass;
            bus_rdata[DIV_LSB +: DIV_W]   = shadow.div;
        end else if (sel_c1) begin
            bus_rdata[PER_W-1:0]          = shadow.per;
            bus_rdata[HI_LSB +: HI_W]     = shadow.hi;
        end
    end

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !load_req);
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // R3
    prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div);
endmodule

// File: rtl/bl_pwm_fsm.sv
module bl_pwm_fsm
    import bl_pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    bypass,
    input  logic    load_req,
    input  timing_t shadow,
    input  logic    tick,
    output logic    run,
    output timing_t act,
    output logic    pwm_out
);
    pwm_state_e       state, state_n;
    logic [PER_W-1:0] ph, ph_n, ph_inc;
    logic             pending, consume;
    timing_t          nxt;

    // Values that govern the next cycle if a boundary is taken now
    assign nxt    = pending ? shadow : act;
    assign ph_inc = ph + 1'b1;
    assign run    = (state != ST_OFF);

    always_comb begin
        state_n = state;
        ph_n    = ph;
        consume = 1'b0;
        unique case (state)
            ST_OFF: begin
                ph_n = '0;
                if (en) begin
                    consume = 1'b1;
                    state_n = (nxt.hi != '0) ? ST_HIGH : ST_LOW;
                end
            end
            ST_HIGH, ST_LOW: begin
                if (!en) begin
                    state_n = ST_OFF;
                    ph_n    = '0;
                end else if (tick) begin
                    if (ph == act.per) begin
                        consume = 1'b1;
                        ph_n    = '0;
                        state_n = (nxt.hi != '0) ? ST_HIGH : ST_LOW;
                    end else begin
                        ph_n    = ph_inc;
                        state_n = ({1'b0, ph_inc} < act.hi) ? ST_HIGH : ST_LOW;
                    end
                end
            end
            default: begin
                state_n = ST_OFF;
                ph_n    = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            ph      <= '0;
            pending <= 1'b0;
            act     <= '0;
        end else begin
            state   <= state_n;
            ph      <= ph_n;
            pending <= (pending && !consume) || load_req || bypass;
            if (consume) act <= nxt;
        end
    end

    always_comb begin
        pwm_out = (state == ST_HIGH);
    end

    // R3
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= act.per);
    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (ph == '0));
    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(tick && ph == act.per)) |=> $stable(act));
    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);
    // R7
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act.hi > {1'b0, act.per}) |-> pwm_out);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic    en, bypass, load_req, tick, run;
    timing_t shadow, act;

    bl_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en       (en),
        .bypass   (bypass),
        .load_req (load_req),
        .shadow   (shadow)
    );

    bl_pwm_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (act.div),
        .tick (tick)
    );

    bl_pwm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .bypass  (bypass),
        .load_req(load_req),
        .shadow  (shadow),
        .tick    (tick),
        .run     (run),
        .act     (act),
        .pwm_out (pwm_out)
    );
endmodule

// File: tb/tb_bl_pwm_top.sv
module tb_bl_pwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int rise_cnt = 0, fall_cnt = 0, since_rise = 0, hrun = 0;
    int last_per = 0, last_high = 0;
    logic prev = 1'b0;

    always #2 clk = ~clk;

    bl_pwm_top dut (.*);

    // Monitor samples pre-edge values at each rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pwm_out && !prev) begin
            last_per   = since_rise;
            since_rise = 1;
            rise_cnt   = rise_cnt + 1;
        end else begin
            since_rise = since_rise + 1;
        end
        if (pwm_out) hrun = (!prev) ? 1 : hrun + 1;
        if (!pwm_out && prev) begin
            last_high = hrun;
            fall_cnt  = fall_cnt + 1;
        end
        prev = pwm_out;
    end

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic commit();
        wr(8'h08, 32'h1);
        wr(8'h08, 32'h0);
    endtask

    task automatic wait_rise();
        int s = rise_cnt;
        for (int n = 0; n < 3000 && rise_cnt == s; n++) @(negedge clk);
    endtask

    task automatic wait_fall();
        int s = fall_cnt;
        for (int n = 0; n < 3000 && fall_cnt == s; n++) @(negedge clk);
    endtask

    task automatic measure(string req, int exp_per, int exp_high);
        wait_rise();
        wait_rise();
        wait_fall();
        check({req, " period"}, last_per, exp_per);
        check({req, " high"}, last_high, exp_high);
    endtask

    task automatic count_high(string req, int win, int exp);
        int h = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
        check(req, h, exp);
    endtask

    task automatic t_reset();
        check("R1 out", int'(pwm_out), 0);
        rd_chk("R1 enable", 8'h00, 32'h0);
        rd_chk("R1 commit", 8'h08, 32'h0);
        rd_chk("R1 ctrl0", 8'h10, 32'h0);
        rd_chk("R1 ctrl1", 8'h14, 32'h0);
    endtask

    task automatic t_program_no_commit();
        wr(8'h10, 32'h0001_0000);
        wr(8'h14, 32'h0003_0009);
        rd_chk("R2 ctrl0", 8'h10, 32'h0001_0000);
        rd_chk("R2 ctrl1", 8'h14, 32'h0003_0009);
        rd_chk("R2 unmapped", 8'h04, 32'h0);
        wr(8'h00, 32'h1);
        rd_chk("R9 enable read", 8'h00, 32'h1);
        count_high("R9 R4 low before commit", 40, 0);
    endtask

    task automatic t_commit();
        commit();
        rd_chk("R2 commit readback", 8'h08, 32'h0);
        measure("R3 div1 per9 hi3", 20, 6);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0002_0004);
        measure("R4 uncommitted", 20, 6);
        commit();
        measure("R3 div0 per4 hi2", 5, 2);
    endtask

    task automatic t_mid_cycle();
        wr(8'h14, 32'h000A_0013);
        commit();
        measure("R3 per19 hi10", 20, 10);
        wait_rise();
        wr(8'h14, 32'h0002_0004);
        commit();
        wait_fall();
        check("R5 current pulse kept", last_high, 10);
        measure("R5 new values next cycle", 5, 2);
    endtask

    task automatic t_extremes();
        wr(8'h14, 32'h0005_0004);
        commit();
        repeat (12) @(negedge clk);
        count_high("R7 hi=per+1 always high", 50, 50);
        wr(8'h14, 32'h0000_0004);
        commit();
        repeat (12) @(negedge clk);
        count_high("R7 hi=0 always low", 50, 0);
    endtask

    task automatic t_bypass();
        wr(8'h10, 32'h0000_0001);
        wr(8'h14, 32'h0003_0007);
        measure("R6 bypass per7 hi3", 8, 3);
        wr(8'h10, 32'h0002_0001);
        measure("R6 bypass div2", 24, 9);
    endtask

    task automatic t_disable();
        int seen = 0;
        wr(8'h00, 32'h0);
        @(negedge clk);
        check("R8 low after disable", int'(pwm_out), 0);
        count_high("R8 stays low", 40, 0);
        rd_chk("R8 ctrl1 kept", 8'h14, 32'h0003_0007);
        rd_chk("R8 ctrl0 kept", 8'h10, 32'h0002_0001);
        wr(8'h00, 32'h1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (pwm_out) seen = 1;
        end
        check("R8 restart high", seen, 1);
        measure("R8 after restart", 24, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_no_commit();
        t_commit();
        t_mid_cycle();
        t_extremes();
        t_bypass();
        t_disable();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule